// File: doc/BRIEF.md
# Two-Step Converter Correction Pipeline

This block is the digital back end of a two-step subranging analog-to-digital converter. On every rising edge of the sample clock it takes a 5-bit coarse code, a 6-bit fine code and two overrange comparator flags from the analog front end. The coarse and fine stages overlap by one bit of redundancy, so the raw sum can spill past the 10-bit range; the block folds the 11 raw bits into one 10-bit word and absorbs that spill.

The merged value is clamped to the 10-bit range. A comparator flag or a clamp forces the matching full-scale code. The word then leaves in two's complement, bit 9 being the sign, or in offset binary when a static select is high. A registered out-of-range flag travels alongside the data. Each result appears after the third rising edge that follows the edge that sampled its inputs. After a synchronous reset or a clock-restart pulse, a data-valid output stays low until the pipeline holds only post-restart samples.

Top module: `adcc_top`

## Requirements
- R1: With both comparator flags low, the merged value is U = coarse*32 + fine - 16. When 0 <= U <= 1023 and fmt_offset = 0, data_out equals U - 512 as a 10-bit two's-complement word, which is U with bit 9 inverted.
- R2: With both comparator flags low, a merged value U < 0 gives the negative full-scale code 200h, and U > 1023 gives the positive full-scale code 1FFh. In either case out_of_range is 1.
- R3: ovr_hi = 1 forces 1FFh, and ovr_lo = 1 with ovr_hi = 0 forces 200h, whatever the codes. In both cases out_of_range is 1. ovr_hi wins when both flags are high.
- R4: out_of_range is 0 exactly when both flags are low and 0 <= U <= 1023.
- R5: Inputs sampled at rising edge N produce the data_out and out_of_range values that appear just after rising edge N+3, and those values are held until edge N+4.
- R6: With fmt_offset = 1, data_out is the offset-binary value: U itself, 3FFh for positive full scale and 000h for negative full scale. fmt_offset is sampled at the output register, at edge N+3.
- R7: After synchronous reset, data_out is 000h, out_of_range is 0 and data_valid is 0.
- R8: An edge at which rst or clk_restart is high clears data_valid. data_valid stays 0 through the next three edges, rises at the fourth edge and then stays 1 until the next reset or restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; all registers act on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clk_restart | input | 1 | Pulse high for one or more edges when the sample clock resumes after a stop |
| coarse_code | input | 5 | First-stage quantizer code |
| fine_code | input | 6 | Second-stage residue code with one bit of redundancy |
| ovr_hi | input | 1 | Comparator: input above the positive limit |
| ovr_lo | input | 1 | Comparator: input below the negative limit |
| fmt_offset | input | 1 | 0 selects two's complement, 1 selects offset binary |
| data_out | output | 10 | Corrected, saturated result |
| out_of_range | output | 1 | High when the word on data_out was clamped |
| data_valid | output | 1 | High when data_out belongs to a sample taken after the last restart |

## Verification
The port assertions assume three things about the inputs. The samples they look back at, four edges earlier, were taken after the last reset. The pipeline data is only trusted while data_valid is high. fmt_offset is judged by its value one edge before the output is read. The bench keeps to this: it drives every input on the falling edge, holds fmt_offset constant through each sweep, and discards its expected history whenever the format or the restart state changes. The sweeps cover every coarse/fine pair, with the comparator flags either idle or cycling through all four combinations. Because consecutive sample values differ, any change in latency shows up as a data mismatch.

// File: rtl/adcc_pkg.sv
package adcc_pkg;

    parameter int COARSE_W = 5;
    parameter int FINE_W   = 6;
    parameter int OUT_W    = 10;
    parameter int LATENCY  = 3;

    localparam int SUM_W         = OUT_W + 2;
    localparam int FINE_SHIFT    = FINE_W - 1;
    localparam int OVERLAP_OFS   = 1 << (FINE_W - 2);
    localparam int CODE_MAX      = (1 << OUT_W) - 1;
    localparam int RESTART_EDGES = LATENCY + 1;

    typedef enum logic [1:0] {
        OVR_NONE = 2'd0,
        OVR_HIGH = 2'd1,
        OVR_LOW  = 2'd2
    } ovr_e;

    typedef struct packed {
        logic [COARSE_W-1:0] coarse;
        logic [FINE_W-1:0]   fine;
        logic                hi;
        logic                lo;
    } raw_t;

    typedef struct packed {
        logic [SUM_W-1:0] sum;
        ovr_e             ovr;
    } merged_t;

    typedef struct packed {
        logic [OUT_W-1:0] code;
        logic             oor;
    } word_t;

    function automatic logic [SUM_W-1:0] overlap_sum(
        input logic [COARSE_W-1:0] coarse,
        input logic [FINE_W-1:0]   fine
    );
        int s;
        s = int'(coarse) * (1 << FINE_SHIFT) + int'(fine) - OVERLAP_OFS;
        return s[SUM_W-1:0];
    endfunction

    function automatic ovr_e ovr_select(input logic hi, input logic lo);
        if (hi)      return OVR_HIGH;
        else if (lo) return OVR_LOW;
        else         return OVR_NONE;
    endfunction

endpackage

// File: rtl/adcc_merge.sv
module adcc_merge
    import adcc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [COARSE_W-1:0] coarse_code,
    input  logic [FINE_W-1:0]   fine_code,
    input  logic                ovr_hi,
    input  logic                ovr_lo,
    output merged_t             merged_q
);

    raw_t raw_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q <= '0;
        end else begin
            raw_q.coarse <= coarse_code;
            raw_q.fine   <= fine_code;
            raw_q.hi     <= ovr_hi;
            raw_q.lo     <= ovr_lo;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            merged_q <= '{sum: '0, ovr: OVR_NONE};
        end else begin
            merged_q.sum <= overlap_sum(raw_q.coarse, raw_q.fine);
            merged_q.ovr <= ovr_select(raw_q.hi, raw_q.lo);
        end
    end

    AST_HI_WINS: assert property (@(posedge clk) disable iff (rst)
        raw_q.hi |=> merged_q.ovr == OVR_HIGH); // R3

endmodule

// File: rtl/adcc_saturate.sv
module adcc_saturate
    import adcc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  merged_t merged_q,
    output word_t   word_q
);

    localparam logic [OUT_W-1:0] TOP_CODE = OUT_W'(CODE_MAX);

    word_t word_d;
    logic  below;
    logic  above;

    always_comb begin
        below = $signed(merged_q.sum) < 0;
        above = $signed(merged_q.sum) > $signed(SUM_W'(CODE_MAX));
        unique case (merged_q.ovr)
            OVR_HIGH: word_d = '{code: TOP_CODE, oor: 1'b1};
            OVR_LOW:  word_d = '{code: '0,       oor: 1'b1};
            default: begin
                if (below)      word_d = '{code: '0,       oor: 1'b1};
                else if (above) word_d = '{code: TOP_CODE, oor: 1'b1};
                else            word_d = '{code: merged_q.sum[OUT_W-1:0], oor: 1'b0};
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) word_q <= '0;
        else     word_q <= word_d;
    end

    AST_NEG_CLAMP: assert property (@(posedge clk) disable iff (rst)
        (merged_q.ovr == OVR_NONE && $signed(merged_q.sum) < 0)
        |=> (word_q.code == '0 && word_q.oor)); // R2

    AST_POS_CLAMP: assert property (@(posedge clk) disable iff (rst)
        (merged_q.ovr == OVR_NONE && $signed(merged_q.sum) > $signed(SUM_W'(CODE_MAX)))
        |=> (word_q.code == TOP_CODE && word_q.oor)); // R2

endmodule

// File: rtl/adcc_format.sv
module adcc_format
    import adcc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fmt_offset,
    input  word_t            word_q,
    output logic [OUT_W-1:0] data_out,
    output logic             out_of_range
);

    logic [OUT_W-1:0] shaped;

    always_comb begin
        shaped = word_q.code;
        if (!fmt_offset) shaped[OUT_W-1] = ~word_q.code[OUT_W-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_out     <= '0;
            out_of_range <= 1'b0;
        end else begin
            data_out     <= shaped;
            out_of_range <= word_q.oor;
        end
    end

    AST_FLAG_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        word_q.oor |=> out_of_range); // R4

endmodule

// File: rtl/adcc_valid.sv
module adcc_valid
    import adcc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clk_restart,
    output logic data_valid
);

    localparam int CNT_W = $clog2(RESTART_EDGES);

    logic [CNT_W-1:0] edge_cnt;

    always_ff @(posedge clk) begin
        if (rst || clk_restart) begin
            edge_cnt   <= '0;
            data_valid <= 1'b0;
        end else if (!data_valid) begin
            if (edge_cnt == CNT_W'(RESTART_EDGES - 1)) data_valid <= 1'b1;
            else                                      edge_cnt   <= edge_cnt + 1'b1;
        end
    end

    AST_RESTART_DROPS: assert property (@(posedge clk) disable iff (rst)
        clk_restart |=> !data_valid); // R8

    AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (data_valid && !clk_restart) |=> data_valid); // R8

endmodule

// File: rtl/adcc_top.sv
module adcc_top
    import adcc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                clk_restart,
    input  logic [COARSE_W-1:0] coarse_code,
    input  logic [FINE_W-1:0]   fine_code,
    input  logic                ovr_hi,
    input  logic                ovr_lo,
    input  logic                fmt_offset,
    output logic [OUT_W-1:0]    data_out,
    output logic                out_of_range,
    output logic                data_valid
);

    merged_t merged_q;
    word_t   word_q;

    adcc_merge i_merge (
        .clk         (clk),
        .rst         (rst),
        .coarse_code (coarse_code),
        .fine_code   (fine_code),
        .ovr_hi      (ovr_hi),
        .ovr_lo      (ovr_lo),
        .merged_q    (merged_q)
    );

    adcc_saturate i_saturate (
        .clk      (clk),
        .rst      (rst),
        .merged_q (merged_q),
        .word_q   (word_q)
    );

    adcc_format i_format (
        .clk          (clk),
        .rst          (rst),
        .fmt_offset   (fmt_offset),
        .word_q       (word_q),
        .data_out     (data_out),
        .out_of_range (out_of_range)
    );

    adcc_valid i_valid (
        .clk         (clk),
        .rst         (rst),
        .clk_restart (clk_restart),
        .data_valid  (data_valid)
    );

    localparam logic [OUT_W-1:0] POS_FS = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] NEG_FS = {1'b1, {(OUT_W-1){1'b0}}};

    AST_HI_FULL_SCALE: assert property (@(posedge clk) disable iff (rst)
        (data_valid && $past(ovr_hi, 4) && !$past(fmt_offset))
        |-> (data_out == POS_FS && out_of_range)); // R3

    AST_LO_FULL_SCALE: assert property (@(posedge clk) disable iff (rst)
        (data_valid && !$past(ovr_hi, 4) && $past(ovr_lo, 4) && !$past(fmt_offset))
        |-> (data_out == NEG_FS && out_of_range)); // R3

    AST_OFFSET_TOP: assert property (@(posedge clk) disable iff (rst)
        (data_valid && $past(ovr_hi, 4) && $past(fmt_offset))
        |-> (data_out == {OUT_W{1'b1}})); // R6

endmodule

// File: tb/test_adcc_top.sv
`timescale 1ns/1ps
module test_adcc_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clk_restart = 1'b0;
    logic [4:0] coarse_code = '0;
    logic [5:0] fine_code = '0;
    logic       ovr_hi = 1'b0;
    logic       ovr_lo = 1'b0;
    logic       fmt_offset = 1'b0;
    logic [9:0] data_out;
    logic       out_of_range;
    logic       data_valid;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [9:0] exp_d  [0:3];
    logic       exp_f  [0:3];
    logic       exp_ok [0:3];
    string      exp_t  [0:3];

    always #5 clk = ~clk;

    adcc_top i_adcc_top (
        .clk          (clk),
        .rst          (rst),
        .clk_restart  (clk_restart),
        .coarse_code  (coarse_code),
        .fine_code    (fine_code),
        .ovr_hi       (ovr_hi),
        .ovr_lo       (ovr_lo),
        .fmt_offset   (fmt_offset),
        .data_out     (data_out),
        .out_of_range (out_of_range),
        .data_valid   (data_valid)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model(input int c, input int f, input logic hi, input logic lo,
                         input logic fmt, output logic [9:0] d, output logic oor,
                         output string tag);
        int s;
        int u;
        s = c * 32 + f - 16;
        oor = 1'b1;
        if (hi)             begin u = 1023; tag = "R3"; end
        else if (lo)        begin u = 0;    tag = "R3"; end
        else if (s < 0)     begin u = 0;    tag = "R2"; end
        else if (s > 1023)  begin u = 1023; tag = "R2"; end
        else                begin u = s; oor = 1'b0; tag = "R1 R4"; end
        if (fmt) begin
            d = u[9:0];
            tag = {tag, " R6"};
        end else begin
            d = u[9:0] ^ 10'h200;
        end
        tag = {tag, " R5"};
    endtask

    task automatic clear_hist();
        for (int k = 0; k < 4; k++) exp_ok[k] = 1'b0;
    endtask

    task automatic step(input int c, input int f, input logic hi, input logic lo);
        logic [9:0] d;
        logic       o;
        string      t;
        @(negedge clk);
        if (exp_ok[3]) begin
            check({exp_t[3], " data"}, int'(data_out), int'(exp_d[3]));
            check({exp_t[3], " R4 flag"}, int'(out_of_range), int'(exp_f[3]));
            check("R8 valid in stream", int'(data_valid), 1);
        end
        for (int k = 3; k > 0; k--) begin
            exp_d[k] = exp_d[k-1]; exp_f[k] = exp_f[k-1];
            exp_ok[k] = exp_ok[k-1]; exp_t[k] = exp_t[k-1];
        end
        coarse_code = c[4:0];
        fine_code   = f[5:0];
        ovr_hi      = hi;
        ovr_lo      = lo;
        model(c, f, hi, lo, fmt_offset, d, o, t);
        exp_d[0] = d; exp_f[0] = o; exp_t[0] = t; exp_ok[0] = 1'b1;
    endtask

    task automatic sweep(input logic cycle_flags);
        for (int c = 0; c < 32; c++) begin
            for (int f = 0; f < 64; f++) begin
                int idx;
                idx = c * 64 + f;
                if (cycle_flags) step(c, f, idx[0], idx[1]);
                else             step(c, f, 1'b0, 1'b0);
            end
        end
        for (int k = 0; k < 4; k++) step(0, 16, 1'b0, 1'b0);
    endtask

    initial begin
        clear_hist();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R7 reset data", int'(data_out), 0);
        check("R7 reset flag", int'(out_of_range), 0);
        check("R7 reset valid", int'(data_valid), 0);

        // R1 R2 R4 R5: full sweep, flags idle, two's complement
        sweep(1'b0);
        // R3: flags cycle through none, hi, lo, both
        sweep(1'b1);

        // R6: switch format, drop stale history
        @(negedge clk);
        fmt_offset = 1'b1;
        clear_hist();
        sweep(1'b1);

        // R8: restart pulse, validity window
        @(negedge clk);
        clear_hist();
        clk_restart = 1'b1;
        @(negedge clk);
        clk_restart = 1'b0;
        check("R8 valid after restart edge", int'(data_valid), 0);
        for (int e = 1; e <= 3; e++) begin
            @(negedge clk);
            check("R8 valid during flush", int'(data_valid), 0);
        end
        @(negedge clk);
        check("R8 valid at fourth edge", int'(data_valid), 1);
        for (int e = 0; e < 4; e++) begin
            @(negedge clk);
            check("R8 valid stays high", int'(data_valid), 1);
        end

        // R7: reset clears outputs mid-run after a full-scale word
        fmt_offset = 1'b0;
        ovr_hi = 1'b1;
        repeat (5) @(negedge clk);
        check("R3 full scale before reset", int'(data_out), 10'h1FF);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        ovr_hi = 1'b0;
        check("R7 data after reset", int'(data_out), 0);
        check("R7 flag after reset", int'(out_of_range), 0);
        check("R7 valid after reset", int'(data_valid), 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule